// File: doc/BRIEF.md
# Load Alignment and Merge Unit

This block sits between the data-memory read port and the register file of a 32-bit in-order core with a one-instruction load delay. For every issued instruction it forms the effective address from a base register and a signed 16-bit offset. For a load it then takes the aligned 32-bit word returned by memory and shapes it into the value the destination register should receive. Memory is little-endian, so byte lane 0 is bits 7:0. The supported shapes are:

- signed and unsigned byte;
- signed and unsigned halfword;
- full word;
- two partial-word merges, "merge-high" and "merge-low", used in pairs to assemble unaligned words.

The merges combine memory bytes with the destination register's previous contents.

A formatted load is not written at once. It is held in a one-entry pending slot and handed to the register file while the next instruction issues. That next instruction therefore still reads the old register. The merges see the newest value of their target register: when the pending slot targets the same register, its data replaces the register-file read. Misaligned halfword and word loads raise an address error that reports the effective address and leave no pending record.

Instruction codes on `op_i`: 0 no load, 1 signed byte, 2 unsigned byte, 3 signed halfword, 4 unsigned halfword, 5 word, 6 merge-high, 7 merge-low.

Top module: `lsu_load_fmt`

## Requirements
- R1: `ea_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, in the same cycle. `ld_data_o` is 0 when `op_i` is 0 (no load).
- R2: Codes 1 and 2 take the byte at lane `ea_o[1:0]` of `mem_rdata_i`. Code 1 copies that byte's bit 7 into bits 31:8. Code 2 clears bits 31:8.
- R3: Codes 3 and 4 take the halfword at bits 15:0 when `ea_o[1]` is 0, and at bits 31:16 when it is 1. Code 3 copies bit 15 of that halfword into bits 31:16. Code 4 clears bits 31:16.
- R4: Code 5 passes `mem_rdata_i` through unchanged.
- R5: `addr_err_o` is 1 exactly when the code is 3 or 4 with `ea_o[0]`=1, or the code is 5 with `ea_o[1:0]`≠0. `err_addr_o` then equals `ea_o`; otherwise it is 0. A faulting load leaves no pending record.
- R6: For code 6, let k=`ea_o[1:0]`. Result bytes below lane k keep the old value. Byte lane i≥k takes memory lane i−k. k=0 therefore gives the whole memory word.
- R7: For code 7, let k=`ea_o[1:0]`. Result byte lane i≤k takes memory lane 3−k+i. Lanes above k keep the old value. k=3 therefore gives the whole memory word.
- R8: The old value used by codes 6 and 7 is the pending data when a pending record exists for register `rd_i`; otherwise it is `rf_old_i`.
- R9: On a clock edge with `valid_i`=1, a non-faulting load to a non-zero register becomes the pending record (register `rd_i`, data `ld_data_o`). Any other issued instruction leaves no pending record.
- R10: A load to register 0 never creates a pending record.
- R11: While `valid_i`=1 and a record is pending, `wb_en_o`=1 and `wb_reg_o`/`wb_data_o` carry that record. `wb_en_o` is 0 at all other times.
- R12: While `valid_i`=0, the pending record holds unchanged. After reset no record is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction issues this cycle |
| op_i | input | 3 | Load code (0 none, 1..7 as listed) |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address offset |
| rd_i | input | 5 | Destination register index |
| rf_old_i | input | 32 | Register-file contents of `rd_i` |
| mem_rdata_i | input | 32 | Aligned word read from memory |
| ea_o | output | 32 | Effective address |
| ld_data_o | output | 32 | Formatted load value |
| addr_err_o | output | 1 | Misaligned access |
| err_addr_o | output | 32 | Faulting address, 0 when no fault |
| wb_en_o | output | 1 | Delayed write to the register file |
| wb_reg_o | output | 5 | Delayed write register |
| wb_data_o | output | 32 | Delayed write data |
| pend_valid_o | output | 1 | A load is pending |
| pend_reg_o | output | 5 | Pending register |
| pend_data_o | output | 32 | Pending data |

## Verification
The assertions check the following on every cycle:

- the extension bits of the byte and halfword loads;
- the rule that byte and merge loads never fault;
- the fault address;
- that a faulting load or a load to register 0 leaves nothing pending;
- that a captured record equals the formatted value and register of the previous issue;
- that the pending slot holds during idle cycles;
- that the write-back port mirrors the slot.

The lane selection, the merge tables for each value of k, and the source of the merges' old value are checked only by the bench. It compares every cycle against a reference model. Its scenarios place the pending load on the same register as a following merge, and on a different one.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [2:0] {
    LD_NONE = 3'd0,
    LD_BS   = 3'd1,
    LD_BU   = 3'd2,
    LD_HS   = 3'd3,
    LD_HU   = 3'd4,
    LD_W    = 3'd5,
    LD_MHI  = 3'd6,
    LD_MLO  = 3'd7
  } ld_op_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic [DW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  ld_op_e        op_i,
  output logic [DW-1:0] ea_o,
  output logic          misalign_o
);
  localparam int unsigned NB  = DW / 8;
  localparam int unsigned LAW = $clog2(NB);

  logic [DW-1:0] off_ext;
  logic [LAW-1:0] lo;

  assign off_ext = {{(DW-OW){offset_i[OW-1]}}, offset_i};
  assign ea_o    = base_i + off_ext;
  assign lo      = ea_o[LAW-1:0];

  always_comb begin
    unique case (op_i)
      LD_HS, LD_HU: misalign_o = lo[0];
      LD_W:         misalign_o = (lo != '0);
      default:      misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_lane_pick.sv
module lsu_lane_pick
  import lsu_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NB  = DW / 8,
  parameter int unsigned LAW = $clog2(NB)
) (
  input  logic [DW-1:0]  mem_i,
  input  logic [LAW-1:0] lo_i,
  input  ld_op_e         op_i,
  output logic [DW-1:0]  data_o
);
  localparam int unsigned NH = NB / 2;

  logic [7:0]  bytes [NB];
  logic [15:0] halves [NH];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bytes[b] = mem_i[8*b +: 8];
  end
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign halves[h] = mem_i[16*h +: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  assign sel_b = bytes[lo_i];
  assign sel_h = halves[lo_i[LAW-1:1]];

  always_comb begin
    unique case (op_i)
      LD_BS:   data_o = {{(DW-8){sel_b[7]}}, sel_b};
      LD_BU:   data_o = {{(DW-8){1'b0}}, sel_b};
      LD_HS:   data_o = {{(DW-16){sel_h[15]}}, sel_h};
      LD_HU:   data_o = {{(DW-16){1'b0}}, sel_h};
      LD_W:    data_o = mem_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_merge.sv
module lsu_merge
  import lsu_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NB  = DW / 8,
  parameter int unsigned LAW = $clog2(NB)
) (
  input  logic [DW-1:0]  mem_i,
  input  logic [DW-1:0]  old_i,
  input  logic [LAW-1:0] lo_i,
  output logic [DW-1:0]  hi_o,
  output logic [DW-1:0]  lo_o
);
  // merge-high: lanes >= k shift up from memory; merge-low: lanes <= k from memory top
  always_comb begin
    int k;
    k = int'(lo_i);
    hi_o = old_i;
    lo_o = old_i;
    for (int i = 0; i < int'(NB); i++) begin
      if (i >= k) hi_o[8*i +: 8] = mem_i[8*(i-k) +: 8];
      if (i <= k) lo_o[8*i +: 8] = mem_i[8*(int'(NB)-1-k+i) +: 8];
    end
  end
endmodule

// File: rtl/lsu_pend_slot.sv
module lsu_pend_slot
  import lsu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned RW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          cap_i,
  input  logic [RW-1:0] reg_i,
  input  logic [DW-1:0] data_i,
  output logic          pv_o,
  output logic [RW-1:0] pr_o,
  output logic [DW-1:0] pd_o,
  output logic          wb_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_o <= 1'b0;
      pr_o <= '0;
      pd_o <= '0;
    end else if (valid_i) begin
      pv_o <= cap_i;
      if (cap_i) begin
        pr_o <= reg_i;
        pd_o <= data_i;
      end
    end
  end

  assign wb_en_o = valid_i & pv_o;
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W,
  parameter int unsigned RW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  logic [RW-1:0] rd_i,
  input  logic [DW-1:0] rf_old_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] ea_o,
  output logic [DW-1:0] ld_data_o,
  output logic          addr_err_o,
  output logic [DW-1:0] err_addr_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_reg_o,
  output logic [DW-1:0] wb_data_o,
  output logic          pend_valid_o,
  output logic [RW-1:0] pend_reg_o,
  output logic [DW-1:0] pend_data_o
);
  localparam int unsigned NB  = DW / 8;
  localparam int unsigned LAW = $clog2(NB);

  ld_op_e        op;
  logic          misalign;
  logic [DW-1:0] pick_d, mhi_d, mlo_d, old_v;
  logic          cap;

  assign op = ld_op_e'(op_i);

  lsu_addr_gen #(.DW(DW), .OW(OW)) u_ag (
    .base_i(base_i), .offset_i(offset_i), .op_i(op),
    .ea_o(ea_o), .misalign_o(misalign)
  );

  lsu_lane_pick #(.DW(DW)) u_pick (
    .mem_i(mem_rdata_i), .lo_i(ea_o[LAW-1:0]), .op_i(op), .data_o(pick_d)
  );

  // newest value of the target: pending load wins over the register file
  assign old_v = (pend_valid_o && pend_reg_o == rd_i) ? pend_data_o : rf_old_i;

  lsu_merge #(.DW(DW)) u_merge (
    .mem_i(mem_rdata_i), .old_i(old_v), .lo_i(ea_o[LAW-1:0]),
    .hi_o(mhi_d), .lo_o(mlo_d)
  );

  always_comb begin
    unique case (op)
      LD_MHI:  ld_data_o = mhi_d;
      LD_MLO:  ld_data_o = mlo_d;
      default: ld_data_o = pick_d;
    endcase
  end

  assign addr_err_o = misalign;
  assign err_addr_o = misalign ? ea_o : '0;
  assign cap        = (op != LD_NONE) && !misalign && (rd_i != '0);

  lsu_pend_slot #(.DW(DW), .RW(RW)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cap_i(cap),
    .reg_i(rd_i), .data_i(ld_data_o),
    .pv_o(pend_valid_o), .pr_o(pend_reg_o), .pd_o(pend_data_o),
    .wb_en_o(wb_en_o)
  );

  assign wb_reg_o  = pend_reg_o;
  assign wb_data_o = pend_data_o;
endmodule

// File: rtl/lsu_load_fmt_chk.sv
module lsu_load_fmt_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned OW = 16,
  parameter int unsigned RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] base_i,
  input logic [OW-1:0] offset_i,
  input logic [RW-1:0] rd_i,
  input logic [DW-1:0] rf_old_i,
  input logic [DW-1:0] mem_rdata_i,
  input logic [DW-1:0] ea_o,
  input logic [DW-1:0] ld_data_o,
  input logic          addr_err_o,
  input logic [DW-1:0] err_addr_o,
  input logic          wb_en_o,
  input logic [RW-1:0] wb_reg_o,
  input logic [DW-1:0] wb_data_o,
  input logic          pend_valid_o,
  input logic [RW-1:0] pend_reg_o,
  input logic [DW-1:0] pend_data_o
);
  logic unused_ok;
  assign unused_ok = ^{base_i, offset_i, rf_old_i, mem_rdata_i};

  assert_bs_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd1 |-> ld_data_o[DW-1:8] == {(DW-8){ld_data_o[7]}});
  assert_bu_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd2 |-> ld_data_o[DW-1:8] == '0);
  assert_hs_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd3 |-> ld_data_o[DW-1:16] == {(DW-16){ld_data_o[15]}});
  assert_hu_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd4 |-> ld_data_o[DW-1:16] == '0);
  assert_no_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd6 || op_i == 3'd7 || op_i == 3'd0)
      |-> !addr_err_o);
  assert_err_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> err_addr_o == ea_o);
  assert_fault_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_err_o |=> !pend_valid_o);
  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != 3'd0 && !addr_err_o && rd_i != '0
      |=> pend_valid_o && pend_reg_o == $past(rd_i) && pend_data_o == $past(ld_data_o));
  assert_r0_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rd_i == '0 |=> !pend_valid_o);
  assert_wb_mirror_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> pend_valid_o && valid_i && wb_reg_o == pend_reg_o && wb_data_o == pend_data_o);
  assert_wb_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wb_en_o);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pend_valid_o) && $stable(pend_reg_o) && $stable(pend_data_o));
endmodule

bind lsu_load_fmt lsu_load_fmt_chk #(.DW(DW), .OW(OW), .RW(RW)) u_chk (.*);

// File: tb/sim_lsu_load_fmt.sv
module sim_lsu_load_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid;
  logic [2:0]  op;
  logic [31:0] base, rf_old, mem;
  logic [15:0] off;
  logic [4:0]  rd;
  logic [31:0] ea, ld, eaddr, wbd, pd;
  logic        aerr, wben, pv;
  logic [4:0]  wbr, pr;

  int checks = 0;
  int errors = 0;
  bit m_pv = 0;
  logic [4:0]  m_pr = '0;
  logic [31:0] m_pd = '0;

  always #5 clk = ~clk;

  lsu_load_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .base_i(base),
    .offset_i(off), .rd_i(rd), .rf_old_i(rf_old), .mem_rdata_i(mem),
    .ea_o(ea), .ld_data_o(ld), .addr_err_o(aerr), .err_addr_o(eaddr),
    .wb_en_o(wben), .wb_reg_o(wbr), .wb_data_o(wbd),
    .pend_valid_o(pv), .pend_reg_o(pr), .pend_data_o(pd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] c, input logic [31:0] a,
                                        input logic [31:0] m, input logic [31:0] o);
    logic [63:0] mm, oo, msk;
    int k;
    logic [7:0] b;
    logic [15:0] h;
    k  = int'(a[1:0]);
    mm = {32'h0, m};
    oo = {32'h0, o};
    b  = m >> (8 * k);
    h  = a[1] ? m[31:16] : m[15:0];
    case (c)
      3'd1: return {{24{b[7]}}, b};
      3'd2: return {24'h0, b};
      3'd3: return {{16{h[15]}}, h};
      3'd4: return {16'h0, h};
      3'd5: return m;
      3'd6: begin
        msk = (64'd1 << (8 * k)) - 1;
        return 32'((oo & msk) | (mm << (8 * k)));
      end
      3'd7: begin
        msk = (64'd1 << (8 * (k + 1))) - 1;
        return 32'((oo & ~msk) | (mm >> (8 * (3 - k))));
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c, input bit fwd);
    case (c)
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return fwd ? "R8" : "R6";
      3'd7: return fwd ? "R8" : "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic step(input bit v, input logic [2:0] c, input logic [31:0] b,
                      input logic [15:0] o, input logic [4:0] r,
                      input logic [31:0] old, input logic [31:0] m);
    logic [31:0] e_ea, e_ld, e_old;
    bit e_err, fwd;
    @(negedge clk);
    valid = v; op = c; base = b; off = o; rd = r; rf_old = old; mem = m;
    #3;
    e_ea  = b + {{16{o[15]}}, o};
    e_err = ((c == 3'd3 || c == 3'd4) && e_ea[0]) || (c == 3'd5 && e_ea[1:0] != 2'b00);
    fwd   = m_pv && m_pr == r;
    e_old = fwd ? m_pd : old;
    e_ld  = model(c, e_ea, m, e_old);
    chk("R1 ea", ea, e_ea);
    chk({tag_of(c, fwd), " data"}, ld, e_ld);
    chk("R5 err", {31'h0, aerr}, {31'h0, e_err});
    chk("R5 err_addr", eaddr, e_err ? e_ea : 32'h0);
    chk("R11 wb_en", {31'h0, wben}, {31'h0, v & m_pv});
    if (v && m_pv) begin
      chk("R11 wb_reg", {27'h0, wbr}, {27'h0, m_pr});
      chk("R11 wb_data", wbd, m_pd);
    end
    chk("R12 pend_valid", {31'h0, pv}, {31'h0, m_pv});
    if (m_pv) begin
      chk("R9 pend_reg", {27'h0, pr}, {27'h0, m_pr});
      chk("R9 pend_data", pd, m_pd);
    end
    @(posedge clk);
    if (v) begin
      m_pv = (c != 3'd0) && !e_err && (r != 5'd0);
      if (m_pv) begin
        m_pr = r;
        m_pd = e_ld;
      end
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    valid = 0; op = 0; base = 0; off = 0; rd = 0; rf_old = 0; mem = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset pend", {31'h0, pv}, 32'h0);
    chk("R11 reset wb", {31'h0, wben}, 32'h0);
    rst_n = 1'b1;

    // R2 all lanes, sign and zero fill
    for (int k = 0; k < 4; k++) begin
      step(1, 3'd1, 32'h1000, 16'(k), 5'd3, 32'h0, 32'h80_7F_C3_15);
      step(1, 3'd2, 32'h1000, 16'(k), 5'd4, 32'h0, 32'h80_7F_C3_15);
    end
    // R3 halves, R5 halfword misalign
    step(1, 3'd3, 32'h2000, 16'h0002, 5'd5, 32'h0, 32'h9234_8001);
    step(1, 3'd4, 32'h2000, 16'h0000, 5'd5, 32'h0, 32'h9234_8001);
    step(1, 3'd3, 32'h2000, 16'h0003, 5'd6, 32'h0, 32'h9234_8001);
    // R4 word, negative offset, R5 word misalign
    step(1, 3'd5, 32'h3004, 16'hFFFC, 5'd7, 32'h0, 32'hDEAD_BEEF);
    step(1, 3'd5, 32'h3004, 16'hFFFE, 5'd7, 32'h0, 32'hDEAD_BEEF);
    // R6 / R7 each k, no forwarding
    for (int k = 0; k < 4; k++) begin
      step(1, 3'd6, 32'h4000, 16'(k), 5'd8, 32'hA1B2_C3D4, 32'h1122_3344);
      step(1, 3'd0, 32'h0, 16'h0, 5'd0, 32'h0, 32'h0);
      step(1, 3'd7, 32'h4000, 16'(k), 5'd9, 32'hA1B2_C3D4, 32'h1122_3344);
      step(1, 3'd0, 32'h0, 16'h0, 5'd0, 32'h0, 32'h0);
    end
    // R8 merge pair on same register uses pending value
    step(1, 3'd7, 32'h5000, 16'h0000, 5'd10, 32'hFFFF_FFFF, 32'hAABB_CCDD);
    step(1, 3'd6, 32'h5000, 16'h0001, 5'd10, 32'h0000_0000, 32'h0102_0304);
    // R8 different register uses rf_old
    step(1, 3'd6, 32'h5000, 16'h0002, 5'd11, 32'h5555_6666, 32'h0102_0304);
    // R10 load to r0, R12 hold through bubbles
    step(1, 3'd5, 32'h6000, 16'h0, 5'd12, 32'h0, 32'hCAFE_F00D);
    step(0, 3'd5, 32'h6000, 16'h0, 5'd13, 32'h0, 32'h1234_5678);
    step(0, 3'd0, 32'h0, 16'h0, 5'd0, 32'h0, 32'h0);
    step(1, 3'd5, 32'h6000, 16'h0, 5'd0, 32'h0, 32'h1111_1111);
    step(1, 3'd0, 32'h0, 16'h0, 5'd0, 32'h0, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 5) != 0, 3'($urandom), $urandom, 16'($urandom % 64) - 16'd32,
           5'($urandom % 4), $urandom, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule